// File: doc/BRIEF.md
# ARINC 429 Transmit Sequencer

This block queues 32-bit ARINC 429 words written by a host over a 16-bit bus and sends them out as return-to-zero serial levels. A word is committed in two writes, low half first and high half second. Up to 32 committed words wait in a queue. Three flags report the queue state: a ready flag, a half-full flag and a full flag.

While the transmit enable is high, the sequencer takes words from the queue one at a time. Each bit drives either a "line one" or a "line zero" output for a half bit period and then leaves both low (null) for the second half. Words are separated by a null word gap. Two bit rates are available. At the fast rate a half bit is 5 clocks and the gap is 40 clocks. At the slow rate both values are eight times longer.

The top bit of each word can be sent as loaded, or replaced by a generated odd or even parity bit. A test input forces the line to null. A self-test loopback provides the serial stream to two receiver inputs: unchanged to the first and with one and zero swapped to the second.

Top module: `a429_tx_seq`

## Requirements
- R1: A word is committed only by a `wr_lo` strobe followed later by a `wr_hi` strobe. The committed word has bit 0 (sent first) equal to `wr_data[0]` of the `wr_lo` write and bit 31 equal to `wr_data[15]` of the `wr_hi` write. A `wr_hi` strobe with no `wr_lo` since the last `wr_hi` commits nothing.
- R2: The queue holds at most 32 words. `full` is 1 exactly when 32 words are held, and a commit attempted while full is discarded.
- R3: `half_full` is 1 when 16 or more words are held and 0 when fewer are held.
- R4: `tx_ready` is 0 from the first edge after a commit. It is 1 when the queue is empty and no word is in its load, data or bit-null phases.
- R5: Words are sent with bit 0 first. Each bit drives `line_one` (bit = 1) or `line_zero` (bit = 0) for one half period, then null for one half period. `line_one` and `line_zero` are never high together.
- R6: When the next word is queued and `tx_en` is high, the null between the data half of bit 31 of one word and bit 0 of the next word lasts one half period plus one gap period: 45 clocks at the fast rate.
- R7: `slow_rate` = 0 selects a 5-clock half period and a 40-clock gap. `slow_rate` = 1 selects 40 and 320 clocks. The rate is sampled when a word is taken from the queue.
- R8: With `par_en` = 1, bit 31 is replaced so that the count of ones in the word is odd (`par_even` = 0) or even (`par_even` = 1). With `par_en` = 0, all 32 bits are sent as loaded. Both controls are sampled when the word is taken from the queue.
- R9: No word is taken from the queue while `tx_en` is low. From idle with a word queued, the first data level appears on the third clock edge after `tx_en` is first sampled high. A word already started always completes.
- R10: `force_null` = 1 makes `line_one` and `line_zero` low from the next clock edge, for as long as it is held. The loopback outputs are not affected.
- R11: With `loop_en` = 1, `lb1_one`/`lb1_zero` follow `line_one`/`line_zero`, and `lb2_one`/`lb2_zero` follow `line_zero`/`line_one`. With `loop_en` = 0, all four loopback outputs are low.
- R12: A synchronous `rst` stops any word at once. After it, the lines are null, the queue is empty, `tx_ready` is 1, and `full` and `half_full` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high master reset |
| wr_lo | input | 1 | Strobe: capture low half of a word |
| wr_hi | input | 1 | Strobe: supply high half and commit the word |
| wr_data | input | 16 | Half-word write data |
| tx_en | input | 1 | Allows words to leave the queue |
| slow_rate | input | 1 | 0 = fast bit timing, 1 = eight times slower |
| par_en | input | 1 | 1 = bit 31 is generated parity |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| force_null | input | 1 | Forces both line outputs low |
| loop_en | input | 1 | Enables the self-test loopback outputs |
| line_one | output | 1 | Drive-one level of the serial line |
| line_zero | output | 1 | Drive-zero level of the serial line |
| lb1_one | output | 1 | Loopback to receiver 1, one level |
| lb1_zero | output | 1 | Loopback to receiver 1, zero level |
| lb2_one | output | 1 | Loopback to receiver 2 (swapped), one level |
| lb2_zero | output | 1 | Loopback to receiver 2 (swapped), zero level |
| tx_ready | output | 1 | Queue empty and no word in progress |
| half_full | output | 1 | 16 or more words queued |
| full | output | 1 | 32 words queued |

## Verification
The hardest state to reach is a full queue that rejects a 33rd commit and then drains exactly 32 correct words. To get there, the stimulus holds `tx_en` low through 33 back-to-back two-write loads, reading the flag thresholds at 15, 16, 31 and 32 words. It then enables transmission and decodes every word from the line, finishing with a long null window that shows the extra word never existed. The 45-clock and 360-clock word gaps only appear when a second word is already queued. For that reason, pairs of words are loaded before the enable rises.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_MARK,
    S_SPACE,
    S_GAP
  } ser_state_e;

  // Top bit of an outgoing word: parity over the lower bits or the loaded bit.
  function automatic logic top_bit(input logic [WORD_W-1:0] w,
                                   input logic par_on, input logic even);
    if (par_on) return (^w[WORD_W-2:0]) ^ ~even;
    return w[WORD_W-1];
  endfunction
endpackage

// File: rtl/a429_tx_load.sv
module a429_tx_load
  import a429_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              q_full,
  output logic              push,
  output logic [WORD_W-1:0] push_word
);
  logic [HALF_W-1:0] lo_q;
  logic              armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      armed_q <= 1'b0;
    end else begin
      if (wr_hi) armed_q <= 1'b0;
      if (wr_lo) begin
        lo_q    <= wr_data;
        armed_q <= 1'b1;
      end
    end
  end

  assign push      = wr_hi & armed_q & ~q_full;
  assign push_word = {wr_data, lo_q};

  // R1: a high-half strobe cannot commit twice without a new low half
  p_single_commit_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_hi && !wr_lo) |=> !push || $past(wr_lo) || wr_lo);
endmodule

// File: rtl/a429_tx_fifo.sv
module a429_tx_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_word,
  input  logic         pop,
  output logic [W-1:0] rd_word,
  output logic         empty,
  output logic         half,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic          do_push, do_pop;

  assign do_push = push && (level != LVL_FULL);
  assign do_pop  = pop && (level != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  // Storage without reset, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_word;
    rd_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign empty = (level == '0);
  assign full  = (level == LVL_FULL);
  assign half  = (level >= LVL_HALF);

  // R2: a full queue stays full and keeps its write pointer without a pop
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full && $stable(wr_ptr));
  // R2: the sequencer only pops a non-empty queue
  p_pop_nonempty_r2: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  // R3: full implies half full
  p_full_half_r3: assert property (@(posedge clk) disable iff (rst)
    full |-> half);
endmodule

// File: rtl/a429_tx_ser.sv
module a429_tx_ser
  import a429_tx_pkg::*;
#(
  parameter int HALF_FAST = 5,
  parameter int SLOW_MULT = 8,
  parameter int GAP_FAST  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_en,
  input  logic              q_empty,
  input  logic [WORD_W-1:0] rd_word,
  input  logic              slow_rate,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              force_null,
  input  logic              loop_en,
  output logic              pop,
  output logic              busy,
  output logic              line_one,
  output logic              line_zero,
  output logic              lb1_one,
  output logic              lb1_zero,
  output logic              lb2_one,
  output logic              lb2_zero
);
  localparam int HALF_SLOW = HALF_FAST * SLOW_MULT;
  localparam int GAP_SLOW  = GAP_FAST * SLOW_MULT;
  localparam int CNT_W     = $clog2(GAP_SLOW + 1);
  localparam int BIT_W     = $clog2(WORD_W);
  // Idle and load cycles are part of the gap seen on the line.
  localparam logic [CNT_W-1:0] HF_END = CNT_W'(HALF_FAST - 1);
  localparam logic [CNT_W-1:0] HS_END = CNT_W'(HALF_SLOW - 1);
  localparam logic [CNT_W-1:0] GF_END = CNT_W'(GAP_FAST - 3);
  localparam logic [CNT_W-1:0] GS_END = CNT_W'(GAP_SLOW - 3);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(WORD_W - 1);

  ser_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [WORD_W-1:0] shreg;
  logic              slow_q;
  logic [CNT_W-1:0]  half_end, gap_end;
  logic              mark_one, mark_zero;

  assign half_end = slow_q ? HS_END : HF_END;
  assign gap_end  = slow_q ? GS_END : GF_END;
  assign pop      = (state == S_IDLE) && tx_en && !q_empty;
  assign busy     = (state == S_LOAD) || (state == S_MARK) || (state == S_SPACE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      shreg  <= '0;
      slow_q <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (pop) state <= S_LOAD;
        S_LOAD: begin
          shreg  <= {top_bit(rd_word, par_en, par_even), rd_word[WORD_W-2:0]};
          slow_q <= slow_rate;
          cnt    <= '0;
          bitn   <= '0;
          state  <= S_MARK;
        end
        S_MARK: begin
          if (cnt == half_end) begin
            cnt   <= '0;
            state <= S_SPACE;
          end else cnt <= cnt + 1'b1;
        end
        S_SPACE: begin
          if (cnt == half_end) begin
            cnt <= '0;
            if (bitn == BIT_END) state <= S_GAP;
            else begin
              bitn  <= bitn + 1'b1;
              shreg <= shreg >> 1;
              state <= S_MARK;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_GAP: begin
          if (cnt == gap_end) begin
            cnt   <= '0;
            state <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mark_one  = (state == S_MARK) &&  shreg[0];
  assign mark_zero = (state == S_MARK) && !shreg[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      line_one  <= 1'b0;
      line_zero <= 1'b0;
      lb1_one   <= 1'b0;
      lb1_zero  <= 1'b0;
      lb2_one   <= 1'b0;
      lb2_zero  <= 1'b0;
    end else begin
      line_one  <= mark_one  && !force_null;
      line_zero <= mark_zero && !force_null;
      lb1_one   <= mark_one  && loop_en;
      lb1_zero  <= mark_zero && loop_en;
      lb2_one   <= mark_zero && loop_en;
      lb2_zero  <= mark_one  && loop_en;
    end
  end

  // R5: never both line levels at once
  p_levels_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(line_one && line_zero));
  // R5: the half-period counter stays inside its window while marking
  p_mark_window_r5: assert property (@(posedge clk) disable iff (rst)
    (state == S_MARK) |-> cnt <= half_end);
  // R9: no word is taken while the enable is low
  p_enable_gate_r9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !tx_en) |=> state != S_LOAD);
  // R10: forced null reaches the line on the next edge
  p_force_null_r10: assert property (@(posedge clk) disable iff (rst)
    $past(force_null) |-> !line_one && !line_zero);
  // R11: loopback silent when not enabled
  p_loop_off_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!loop_en) |-> !(lb1_one || lb1_zero || lb2_one || lb2_zero));
endmodule

// File: rtl/a429_tx_seq.sv
module a429_tx_seq
  import a429_tx_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int HALF_FAST = 5,
  parameter int SLOW_MULT = 8,
  parameter int GAP_FAST  = 40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [HALF_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              slow_rate,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              force_null,
  input  logic              loop_en,
  output logic              line_one,
  output logic              line_zero,
  output logic              lb1_one,
  output logic              lb1_zero,
  output logic              lb2_one,
  output logic              lb2_zero,
  output logic              tx_ready,
  output logic              half_full,
  output logic              full
);
  logic              push, pop, q_empty, busy;
  logic [WORD_W-1:0] push_word, rd_word;

  a429_tx_load u_load (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .q_full(full), .push(push), .push_word(push_word)
  );

  a429_tx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .push_word(push_word), .pop(pop),
    .rd_word(rd_word), .empty(q_empty), .half(half_full), .full(full)
  );

  a429_tx_ser #(.HALF_FAST(HALF_FAST), .SLOW_MULT(SLOW_MULT), .GAP_FAST(GAP_FAST)) u_ser (
    .clk(clk), .rst(rst), .tx_en(tx_en), .q_empty(q_empty), .rd_word(rd_word),
    .slow_rate(slow_rate), .par_en(par_en), .par_even(par_even),
    .force_null(force_null), .loop_en(loop_en), .pop(pop), .busy(busy),
    .line_one(line_one), .line_zero(line_zero), .lb1_one(lb1_one),
    .lb1_zero(lb1_zero), .lb2_one(lb2_one), .lb2_zero(lb2_zero)
  );

  assign tx_ready = q_empty && !busy;

  // R4: a committed word drops the ready flag on the next edge
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (rst)
    push |=> !tx_ready);
  // R4: a line level is only driven while not ready
  p_ready_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (line_one || line_zero) |-> !tx_ready);
endmodule

// File: tb/a429_tx_seq_tb_top.sv
`timescale 1ns/1ps
module a429_tx_seq_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_lo = 0, wr_hi = 0, tx_en = 0, slow_rate = 0;
  logic par_en = 1, par_even = 0, force_null = 0, loop_en = 0;
  logic [15:0] wr_data = '0;
  logic line_one, line_zero, lb1_one, lb1_zero, lb2_one, lb2_zero;
  logic tx_ready, half_full, full;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  a429_tx_seq dut_i (
    .clk(clk), .rst(rst), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
    .tx_en(tx_en), .slow_rate(slow_rate), .par_en(par_en), .par_even(par_even),
    .force_null(force_null), .loop_en(loop_en), .line_one(line_one),
    .line_zero(line_zero), .lb1_one(lb1_one), .lb1_zero(lb1_zero),
    .lb2_one(lb2_one), .lb2_zero(lb2_zero), .tx_ready(tx_ready),
    .half_full(half_full), .full(full)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expw(input logic [31:0] w, input bit pe, input bit ev);
    if (pe) return {(^w[30:0]) ^ ~ev, w[30:0]};
    return w;
  endfunction

  function automatic bit act();
    return line_one || line_zero;
  endfunction

  task automatic load_word(input logic [31:0] w);
    @(negedge clk); wr_data = w[15:0]; wr_lo = 1;
    @(negedge clk); wr_lo = 0; wr_data = w[31:16]; wr_hi = 1;
    @(negedge clk); wr_hi = 0;
  endtask

  // Decode one word from the line; counts run-length errors.
  task automatic grab_word(input int half, output logic [31:0] w, output int bad);
    int n = 0;
    w = '0; bad = 0;
    while (!act() && n < 20000) begin n++; @(negedge clk); end
    for (int b = 0; b < 32; b++) begin
      int d = 0;
      w[b] = line_one;
      while (act()) begin d++; @(negedge clk); end
      if (d != half) bad++;
      if (b < 31) begin
        int z = 0;
        while (!act() && z < 20000) begin z++; @(negedge clk); end
        if (z != half) bad++;
      end
    end
  endtask

  task automatic count_null(input int cap, output int z);
    z = 0;
    while (!act() && z < cap) begin z++; @(negedge clk); end
  endtask

  task automatic t_reset();
    rst = 1; repeat (3) @(negedge clk); rst = 0; @(negedge clk);
    chk(tx_ready == 1, "R12", "ready after reset", tx_ready, 1);
    chk(!full && !half_full, "R12", "flags after reset", {full, half_full}, 0);
    chk(!act(), "R12", "line null after reset", {line_one, line_zero}, 0);
  endtask

  task automatic t_orphan_hi();
    @(negedge clk); wr_data = 16'hBEEF; wr_hi = 1;
    @(negedge clk); wr_hi = 0; @(negedge clk);
    chk(tx_ready == 1, "R1", "lone high half commits nothing", tx_ready, 1);
  endtask

  task automatic t_enable_gate();
    logic [31:0] got; int bad, z;
    par_en = 1; par_even = 0;
    load_word(32'h1234_5678);
    chk(tx_ready == 0, "R4", "ready low after commit", tx_ready, 0);
    load_word(32'h0F0F_00FF);
    count_null(50, z);
    chk(z == 50, "R9", "no start while enable low", z, 50);
    tx_en = 1;
    @(negedge clk); chk(!act(), "R9", "null after edge 1", {line_one, line_zero}, 0);
    @(negedge clk); chk(!act(), "R9", "null after edge 2", {line_one, line_zero}, 0);
    @(negedge clk); chk(line_one == expw(32'h1234_5678, 1, 0) * 0 + 1'b0 && act(), "R9",
                        "first bit on edge 3", {line_one, line_zero}, 1);
    tx_en = 0;
    par_even = 1;
    grab_word(5, got, bad);
    chk(got == expw(32'h1234_5678, 1, 0), "R8", "odd parity word", got, expw(32'h1234_5678, 1, 0));
    chk(bad == 0, "R5", "fast bit timing", bad, 0);
    count_null(200, z);
    chk(z == 200, "R9", "word completes, next waits for enable", z, 200);
    tx_en = 1;
    grab_word(5, got, bad);
    chk(got == expw(32'h0F0F_00FF, 1, 1), "R8", "even parity word", got, expw(32'h0F0F_00FF, 1, 1));
    repeat (8) @(negedge clk);
    chk(tx_ready == 1, "R4", "ready high after last word", tx_ready, 1);
  endtask

  task automatic t_gap_raw();
    logic [31:0] got; int bad, z;
    par_en = 0; tx_en = 0;
    load_word(32'h8000_0001); load_word(32'hA5A5_5A5A);
    tx_en = 1;
    grab_word(5, got, bad);
    chk(got == 32'h8000_0001, "R8", "parity bypass sends bit 31", got, 32'h8000_0001);
    count_null(1000, z);
    chk(z == 45, "R6", "fast word gap", z, 45);
    grab_word(5, got, bad);
    chk(got == 32'hA5A5_5A5A && bad == 0, "R5", "second word bit 0 first", got, 32'hA5A5_5A5A);
  endtask

  task automatic t_slow();
    logic [31:0] got; int bad, z;
    tx_en = 0; slow_rate = 1;
    load_word(32'h0000_C003); load_word(32'h7000_0000);
    tx_en = 1;
    grab_word(40, got, bad);
    chk(bad == 0, "R7", "slow half period 40", bad, 0);
    count_null(2000, z);
    chk(z == 360, "R7", "slow word gap", z, 360);
    grab_word(40, got, bad);
    chk(got == 32'h7000_0000, "R7", "slow word content", got, 32'h7000_0000);
    slow_rate = 0;
  endtask

  task automatic t_fill();
    logic [31:0] got; int bad, z, wrong;
    tx_en = 0; par_en = 1; par_even = 0;
    repeat (100) @(negedge clk);
    for (int k = 1; k <= 33; k++) begin
      load_word(32'h0100_0000 * k + k);
      if (k == 15) chk(!half_full, "R3", "15 words not half", half_full, 0);
      if (k == 16) chk(half_full, "R3", "16 words half", half_full, 1);
      if (k == 31) chk(!full, "R2", "31 words not full", full, 0);
      if (k == 32) chk(full, "R2", "32 words full", full, 1);
    end
    chk(full, "R2", "still full after extra load", full, 1);
    tx_en = 1; wrong = 0;
    for (int k = 1; k <= 32; k++) begin
      grab_word(5, got, bad);
      if (got != expw(32'h0100_0000 * k + k, 1, 0) || bad != 0) wrong++;
    end
    chk(wrong == 0, "R2", "32 queued words in order", wrong, 0);
    count_null(400, z);
    chk(z == 400, "R2", "33rd load was discarded", z, 400);
  endtask

  task automatic t_force_loop();
    int mis = 0, lbact = 0, lineact = 0;
    loop_en = 1;
    load_word(32'h3C3C_C3C3);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk);
      if (lb1_one != line_one || lb1_zero != line_zero ||
          lb2_one != line_zero || lb2_zero != line_one) mis++;
    end
    chk(mis == 0, "R11", "loopback pairs track line", mis, 0);
    force_null = 1; @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (act()) lineact++;
      if (lb1_one || lb1_zero) lbact++;
    end
    chk(lineact == 0, "R10", "line forced null", lineact, 0);
    chk(lbact > 0, "R10", "loopback keeps running", lbact, 1);
    force_null = 0; loop_en = 0;
    while (!tx_ready) @(negedge clk);
    repeat (60) @(negedge clk);
    load_word(32'hFFFF_0000);
    lbact = 0; lineact = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (act()) lineact++;
      if (lb1_one || lb1_zero || lb2_one || lb2_zero) lbact++;
    end
    chk(lbact == 0 && lineact > 0, "R11", "loopback off when disabled", lbact, 0);
    while (!tx_ready) @(negedge clk);
    repeat (60) @(negedge clk);
  endtask

  task automatic t_reset_mid();
    int z;
    load_word(32'h5555_AAAA); load_word(32'h1111_2222); load_word(32'h3333_4444);
    while (!act()) @(negedge clk);
    repeat (20) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk(!act(), "R12", "line null after reset", {line_one, line_zero}, 0);
    chk(tx_ready && !full && !half_full, "R12", "flags after mid-word reset",
        {tx_ready, full, half_full}, 4);
    count_null(500, z);
    chk(z == 500, "R12", "queue cleared by reset", z, 500);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_orphan_hi();
    t_enable_gate();
    t_gap_raw();
    t_slow();
    t_fill();
    t_force_loop();
    t_reset_mid();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(190000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog R12: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule